// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupter

This peripheral sits beside a small cluster of harts and supplies each of them with two interrupt sources. The first is a software interrupt: a one-bit flag per hart that any hart can set or clear through the register bus. A hart uses it to signal another hart. The second is a timer interrupt. It is derived from one shared 64-bit time counter and a private 64-bit compare value held for each hart.

The time counter runs freely from reset. It advances by one on every tick of an internal prescaler that divides the system clock down to the timebase rate. With a 125 MHz system clock, a prescale factor of about 12 gives roughly the nominal 10 MHz. Software cannot write the counter.

A hart's timer interrupt is a level output. It stays high for as long as that hart's compare value is at or below the counter. Software clears it by programming a compare value in the future. Because the bus is 32 bits wide, each compare value is written one half at a time, and the other stored half is kept. All accesses are 32-bit words. A read returns its data on the clock after the request.

Top module: `core_timer_swint`

## Requirements
- R1: The software-interrupt word of hart h is at byte offset 4*h. A write there sets that hart's software interrupt output to bit 0 of the write data. A read returns the flag in bit 0, with bits 31..1 zero. The flag holds its value between writes.
- R2: The compare value of hart h sits at offset 0x4000 + 8*h. The low 32 bits are at +0 and the high 32 bits at +4. Writing one half replaces only that half, and both halves read back what was stored.
- R3: The time counter reads at 0xBFF8 (bits 31..0) and 0xBFFC (bits 63..32). Writes to these two offsets leave the counter unchanged.
- R4: The time counter rises by exactly one per tick, and a tick occurs once every PRESCALE clocks. Over a window of 40 clocks with PRESCALE = 4, the counter therefore grows by 10.
- R5: Each clock, the timer interrupt of hart h is registered as the unsigned 64-bit comparison compare[h] <= time, taken on the values before that edge. After a compare value ahead of the counter is written, the output drops one clock later and rises again once the counter reaches that value.
- R6: After reset, the counter and all compare values are zero, every software interrupt is low, and every timer interrupt is high.
- R7: Certain offsets read as zero and ignore writes: any offset with bits 1..0 not equal to 00, any offset past the last hart in either region, and any other unmapped offset.
- R8: Read data is registered. It shows the addressed word on the clock after a read request and is zero on the clock after any cycle without a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released through a two-stage synchronizer |
| bus_sel | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid on the clock after the request |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt level |
| soft_irq | output | NUM_HARTS | Per-hart software interrupt level |

## Verification
The checker assumes the bus presents at most one request per clock. It also assumes that request fields are stable around the sampling edge, and that the counter never wraps within a run. The stimulus meets these assumptions as follows. It drives every bus field from the falling edge and holds a request for exactly one clock. It keeps the compare values small or clearly far ahead, and it ends long before the counter leaves its low word. Misaligned and out-of-range offsets are driven only as single isolated writes or reads. This lets the checker's stability properties tie any change of state to a legal access.

// File: rtl/ctsi_pkg.sv
package ctsi_pkg;

  // Region origins; decode and software depend on these values.
  localparam logic [31:0] SWI_ORIGIN  = 32'h0000_0000;
  localparam logic [31:0] CMP_ORIGIN  = 32'h0000_4000;
  localparam logic [31:0] TIME_WORD0  = 32'h0000_BFF8;
  localparam logic [31:0] TIME_WORD1  = 32'h0000_BFFC;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SWI,
    TGT_CMP_LO,
    TGT_CMP_HI,
    TGT_TIME_LO,
    TGT_TIME_HI
  } target_e;

endpackage

// File: rtl/ctsi_tick_gen.sv
module ctsi_tick_gen #(
  parameter int unsigned PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (PRESCALE <= 1) begin : g_every_clock
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign tick = 1'b1;
    end else begin : g_divider
      localparam int unsigned CW = $clog2(PRESCALE);
      localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;

      always_comb begin
        if (cnt_q == LAST) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
      end

      assign tick = (cnt_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end
    end
  endgenerate

endmodule

// File: rtl/ctsi_decode.sv
module ctsi_decode
  import ctsi_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned HIDX_W    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output target_e           tgt,
  output logic [HIDX_W-1:0] hart
);

  localparam logic [31:0] SWI_END = SWI_ORIGIN + 32'(4 * NUM_HARTS);
  localparam logic [31:0] CMP_END = CMP_ORIGIN + 32'(8 * NUM_HARTS);

  logic [31:0] a;
  logic [31:0] rel_swi;
  logic [31:0] rel_cmp;

  assign a       = 32'(addr);
  assign rel_swi = (a - SWI_ORIGIN) >> 2;
  assign rel_cmp = (a - CMP_ORIGIN) >> 3;

  always_comb begin
    tgt  = TGT_NONE;
    hart = '0;
    if (a[1:0] == 2'b00) begin
      if (a < SWI_END) begin
        tgt  = TGT_SWI;
        hart = HIDX_W'(rel_swi);
      end else if ((a >= CMP_ORIGIN) && (a < CMP_END)) begin
        tgt  = a[2] ? TGT_CMP_HI : TGT_CMP_LO;
        hart = HIDX_W'(rel_cmp);
      end else if (a == TIME_WORD0) begin
        tgt = TGT_TIME_LO;
      end else if (a == TIME_WORD1) begin
        tgt = TGT_TIME_HI;
      end
    end
  end

endmodule

// File: rtl/ctsi_hart_slot.sv
module ctsi_hart_slot (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [63:0] now,
  input  logic        wr_swi,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  output logic [63:0] cmp_q,
  output logic        swi_q,
  output logic        tirq_q
);

  logic [63:0] cmp_d;
  logic        cmp_en;
  logic        swi_d;
  logic        tirq_d;

  always_comb begin
    cmp_d = cmp_q;
    if (wr_lo) cmp_d[31:0]  = wdata;
    if (wr_hi) cmp_d[63:32] = wdata;
    cmp_en = wr_lo | wr_hi;
    swi_d  = wdata[0];
    tirq_d = (cmp_q <= now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      swi_q  <= 1'b0;
      tirq_q <= 1'b1;
    end else begin
      if (cmp_en) cmp_q <= cmp_d;
      if (wr_swi) swi_q <= swi_d;
      tirq_q <= tirq_d;
    end
  end

endmodule

// File: rtl/core_timer_swint.sv
module core_timer_swint
  import ctsi_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned PRESCALE  = 4,
  parameter int unsigned ADDR_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_HARTS-1:0] timer_irq,
  output logic [NUM_HARTS-1:0] soft_irq
);

  localparam int unsigned HIDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // Shared timebase.
  logic        tick;
  logic [63:0] time_q;
  logic [63:0] time_d;

  ctsi_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
    .clk   (clk),
    .rst_n (rst_core_n),
    .tick  (tick)
  );

  assign time_d = time_q + 64'd1;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) time_q <= '0;
    else if (tick)   time_q <= time_d;
  end

  // Address decode.
  target_e           tgt;
  logic [HIDX_W-1:0] hart;
  logic              wr_req;
  logic              rd_req;

  ctsi_decode #(
    .NUM_HARTS (NUM_HARTS),
    .ADDR_W    (ADDR_W),
    .HIDX_W    (HIDX_W)
  ) u_dec (
    .addr (bus_addr),
    .tgt  (tgt),
    .hart (hart)
  );

  assign wr_req = bus_sel & bus_we;
  assign rd_req = bus_sel & ~bus_we;

  // Per-hart state.
  logic [63:0]             cmp_arr [NUM_HARTS];
  logic [64*NUM_HARTS-1:0] cmp_flat;

  generate
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
      logic sel_me;
      assign sel_me = (hart == HIDX_W'(h));

      ctsi_hart_slot u_slot (
        .clk    (clk),
        .rst_n  (rst_core_n),
        .now    (time_q),
        .wr_swi (wr_req & sel_me & (tgt == TGT_SWI)),
        .wr_lo  (wr_req & sel_me & (tgt == TGT_CMP_LO)),
        .wr_hi  (wr_req & sel_me & (tgt == TGT_CMP_HI)),
        .wdata  (bus_wdata),
        .cmp_q  (cmp_arr[h]),
        .swi_q  (soft_irq[h]),
        .tirq_q (timer_irq[h])
      );

      assign cmp_flat[64*h +: 64] = cmp_arr[h];
    end
  endgenerate

  // Read path.
  logic [31:0] rd_d;
  logic [31:0] rd_q;

  always_comb begin
    rd_d = '0;
    if (rd_req) begin
      case (tgt)
        TGT_SWI:     rd_d = {31'd0, soft_irq[hart]};
        TGT_CMP_LO:  rd_d = cmp_arr[hart][31:0];
        TGT_CMP_HI:  rd_d = cmp_arr[hart][63:32];
        TGT_TIME_LO: rd_d = time_q[31:0];
        TGT_TIME_HI: rd_d = time_q[63:32];
        default:     rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rd_q <= '0;
    else             rd_q <= rd_d;
  end

  assign bus_rdata = rd_q;

endmodule

// File: rtl/ctsi_checker.sv
module ctsi_checker #(
  parameter int unsigned NUM_HARTS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_sel,
  input logic                    bus_we,
  input logic [1:0]              addr_lo,
  input logic [31:0]             bus_rdata,
  input logic                    tick,
  input logic [63:0]             time_q,
  input logic [64*NUM_HARTS-1:0] cmp_flat,
  input logic [NUM_HARTS-1:0]    timer_irq,
  input logic [NUM_HARTS-1:0]    soft_irq
);

  // R4: counter only moves on a tick, and then by one.
  assert_time_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(time_q));

  assert_time_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (time_q == $past(time_q) + 64'd1));

  // R8: no read request means zero read data next clock.
  assert_rdata_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_we) |=> (bus_rdata == 32'd0));

  // R1: flags move only on a write.
  assert_swi_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we) |=> $stable(soft_irq));

  // R7: misaligned writes touch nothing.
  assert_misalign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && (addr_lo != 2'b00)) |=> ($stable(soft_irq) && $stable(cmp_flat)));

  // R5: each timer output is the registered comparison.
  generate
    for (genvar g = 0; g < NUM_HARTS; g++) begin : g_cmp
      assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        timer_irq[g] == ($past(cmp_flat[64*g +: 64]) <= $past(time_q)));
    end
  endgenerate

endmodule

bind core_timer_swint ctsi_checker #(.NUM_HARTS(NUM_HARTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .addr_lo   (bus_addr[1:0]),
  .bus_rdata (bus_rdata),
  .tick      (tick),
  .time_q    (time_q),
  .cmp_flat  (cmp_flat),
  .timer_irq (timer_irq),
  .soft_irq  (soft_irq)
);

// File: tb/tb_core_timer_swint.sv
`timescale 1ns/1ps
module tb_core_timer_swint;

  localparam int N   = 4;
  localparam int PRE = 4;

  logic         clk;
  logic         rst_n;
  logic         bus_sel;
  logic         bus_we;
  logic [15:0]  bus_addr;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata;
  logic [N-1:0] timer_irq;
  logic [N-1:0] soft_irq;

  core_timer_swint #(.NUM_HARTS(N), .PRESCALE(PRE), .ADDR_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .timer_irq(timer_irq), .soft_irq(soft_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit armed = 0;
  bit done  = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model.
  logic [63:0]  m_time;
  logic [63:0]  m_cmp [N];
  logic [N-1:0] m_sw;
  logic [N-1:0] m_tirq;
  logic [31:0]  m_rdata;
  int           m_pre;
  bit           m_s1, m_s2;

  function automatic logic [31:0] m_read(input int a);
    if (a % 4 != 0) return 32'd0;
    if (a < 4 * N) return {31'd0, m_sw[a / 4]};
    if (a >= 'h4000 && a < 'h4000 + 8 * N) begin
      if (a % 8 == 4) return m_cmp[(a - 'h4000) / 8][63:32];
      return m_cmp[(a - 'h4000) / 8][31:0];
    end
    if (a == 'hBFF8) return m_time[31:0];
    if (a == 'hBFFC) return m_time[63:32];
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_time = 0; m_sw = 0; m_tirq = '1; m_rdata = 0; m_pre = 0;
      for (int h = 0; h < N; h++) m_cmp[h] = 0;
    end else begin
      if (m_s2) begin
        logic [31:0]  nrd;
        logic [N-1:0] nti;
        int           a;
        nrd = (bus_sel && !bus_we) ? m_read(int'(bus_addr)) : 32'd0;
        for (int h = 0; h < N; h++) nti[h] = (m_cmp[h] <= m_time);
        if (m_pre == PRE - 1) begin m_pre = 0; m_time = m_time + 1; end
        else m_pre = m_pre + 1;
        if (bus_sel && bus_we) begin
          a = int'(bus_addr);
          if (a % 4 == 0) begin
            if (a < 4 * N) m_sw[a / 4] = bus_wdata[0];
            else if (a >= 'h4000 && a < 'h4000 + 8 * N) begin
              if (a % 8 == 4) m_cmp[(a - 'h4000) / 8][63:32] = bus_wdata;
              else            m_cmp[(a - 'h4000) / 8][31:0]  = bus_wdata;
            end
          end
        end
        m_rdata = nrd;
        m_tirq  = nti;
      end
      m_s2 = m_s1;
      m_s1 = 1;
    end
    armed = 1;
  end

  // Compare with the model on every clock.
  always @(negedge clk) begin
    if (armed && !done) begin
      chk(timer_irq == m_tirq, "R5", 64'(timer_irq), 64'(m_tirq));
      chk(soft_irq == m_sw,    "R1", 64'(soft_irq),  64'(m_sw));
      chk(bus_rdata == m_rdata, "R8", 64'(bus_rdata), 64'(m_rdata));
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_wdata = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, t1, t2;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R6: reset state.
    chk(timer_irq == '1, "R6", 64'(timer_irq), 64'hF);
    chk(soft_irq == '0,  "R6", 64'(soft_irq), 64'h0);
    rd(16'h4008, v); chk(v == 0, "R6", 64'(v), 0);
    rd(16'hBFFC, v); chk(v == 0, "R3", 64'(v), 0);

    // R1: software flags.
    wr(16'h0008, 32'h1);
    chk(soft_irq == 4'b0100, "R1", 64'(soft_irq), 64'h4);
    rd(16'h0008, v); chk(v == 32'h1, "R1", 64'(v), 1);
    wr(16'h000C, 32'hFFFF_FFFF);
    rd(16'h000C, v); chk(v == 32'h1, "R1", 64'(v), 1);
    wr(16'h0008, 32'hFFFF_FFFE);
    chk(soft_irq == 4'b1000, "R1", 64'(soft_irq), 64'h8);

    // R2: halves of hart 1's compare value.
    wr(16'h4008, 32'h1234_5678);
    wr(16'h400C, 32'h0000_0001);
    rd(16'h4008, v); chk(v == 32'h1234_5678, "R2", 64'(v), 64'h12345678);
    rd(16'h400C, v); chk(v == 32'h1, "R2", 64'(v), 1);
    wr(16'h4008, 32'h0000_0010);
    rd(16'h400C, v); chk(v == 32'h1, "R2", 64'(v), 1);
    rd(16'h4008, v); chk(v == 32'h10, "R2", 64'(v), 64'h10);
    chk(timer_irq[1] == 1'b0, "R5", 64'(timer_irq[1]), 0);

    // R5: future compare drops, then re-raises.
    rd(16'hBFF8, t1);
    wr(16'h4000, t1 + 32'd30);
    @(negedge clk);
    chk(timer_irq[0] == 1'b0, "R5", 64'(timer_irq[0]), 0);
    repeat (200) @(negedge clk);
    chk(timer_irq[0] == 1'b1, "R5", 64'(timer_irq[0]), 1);

    // R3: counter is read-only.
    wr(16'hBFF8, 32'hFFFF_FFFF);
    wr(16'hBFFC, 32'hFFFF_FFFF);
    rd(16'hBFFC, v); chk(v == 0, "R3", 64'(v), 0);
    rd(16'hBFF8, v); chk(v < 32'h1000, "R3", 64'(v), 64'h1000);

    // R4: ten ticks across forty clocks.
    rd(16'hBFF8, t1);
    repeat (39) @(negedge clk);
    rd(16'hBFF8, t2);
    chk(t2 - t1 == 32'd10, "R4", 64'(t2 - t1), 10);

    // R7: unmapped and misaligned offsets.
    rd(16'h0002, v); chk(v == 0, "R7", 64'(v), 0);
    rd(16'h4020, v); chk(v == 0, "R7", 64'(v), 0);
    rd(16'h1000, v); chk(v == 0, "R7", 64'(v), 0);
    rd(16'h4009, v); chk(v == 0, "R7", 64'(v), 0);
    wr(16'h0001, 32'h1);
    wr(16'h0010, 32'h1);
    chk(soft_irq == 4'b1000, "R7", 64'(soft_irq), 64'h8);
    wr(16'h400A, 32'hDEAD_BEEF);
    rd(16'h4008, v); chk(v == 32'h10, "R7", 64'(v), 64'h10);

    // R8: data appears one clock after request, then clears.
    rd(16'h000C, v);
    chk(v == 32'h1, "R8", 64'(v), 1);
    @(negedge clk);
    chk(bus_rdata == 0, "R8", 64'(bus_rdata), 0);

    repeat (5) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule